// File: doc/BRIEF.md
# Dual-Range Current Acquisition Combiner

This block serves one input channel of a wide-range current digitiser. It slices time into fixed acquisition periods of `PERIOD_CYCLES` clocks, which is 2 µs at the default 50 MHz. During each period it counts the toggle strobes raised by a dual-polarity current-to-frequency front end. At the last cycle of every period it strobes the ADC and captures the ADC reading.

When a period closes, the block turns what it measured into one signed integral. In counting mode the integral is the pulse count times a charge-per-pulse scale plus the signed ADC difference across the period times an ADC scale. In direct mode the integral is the boundary ADC reading times a direct scale.

Range selection is automatic. A period whose pulse count reaches the limit moves the channel to direct mode. A direct-mode period whose boundary ADC reading falls below a low threshold moves it back to counting mode. Each integral is tagged with the mode that produced it, so downstream logic receives one sample per period whatever the range.

Top module: `dri_combiner`

## Requirements
- R1: `adc_strobe_o` is high for exactly one cycle in every `PERIOD_CYCLES` cycles. The first strobe falls in cycle `PERIOD_CYCLES-1` after reset is released, and that strobe cycle is the last cycle of the period.
- R2: During reset and right after it, `sample_valid_o`, `sample_o`, `sample_mode_o` and `range_o` are 0. `range_o`=0 means counting mode and 1 means direct mode.
- R3: The first period boundary after reset only captures the ADC reading. It produces no `sample_valid_o`.
- R4: After every later boundary, `sample_valid_o` is high for exactly the one cycle that follows the strobe cycle, and `sample_o` holds the integral in that cycle.
- R5: In counting mode, `sample_o` = N·`PULSE_SCALE` + (A_now − A_prev)·`ADC_SCALE`. N is the number of high cycles of `up_strobe_i` plus the number of high cycles of `dn_strobe_i` within the period, including the strobe cycle. A cycle with both strobes high counts two.
- R6: The ADC difference is signed, so a falling ADC reading makes the difference term negative.
- R7: N saturates at `cnt_limit_i`.
- R8: When N reaches `cnt_limit_i`, `range_o` becomes 1 in the cycle after that period's strobe.
- R9: In direct mode, `sample_o` = A_now·`DIRECT_SCALE`, and both pulse strobes are ignored.
- R10: In direct mode, a boundary reading strictly below `direct_low_i` returns `range_o` to 0. A reading equal to the threshold keeps direct mode.
- R11: `sample_mode_o` equals the mode that was in force during the period the sample covers.
- R12: `range_o` changes only in the cycle that follows a strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_strobe_i | input | 1 | Front-end toggle strobe, one direction |
| dn_strobe_i | input | 1 | Front-end toggle strobe, other direction |
| adc_data_i | input | ADC_W | ADC reading, captured in the strobe cycle |
| cnt_limit_i | input | CNT_W | Pulse count that forces direct mode |
| direct_low_i | input | ADC_W | ADC level below which counting mode resumes |
| adc_strobe_o | output | 1 | ADC conversion strobe, high in the last cycle of each period |
| range_o | output | 1 | Current mode: 0 counting, 1 direct |
| sample_o | output | OUT_W | Signed period integral |
| sample_valid_o | output | 1 | Integral valid |
| sample_mode_o | output | 1 | Mode that produced the integral |

## Verification
The counting path is swept through every pulse total from zero to just below the limit. The totals are split between the two strobes and overlap in the same cycles, so double counting in one cycle is separated from a count that drops one of the strobes. The ADC readings rise and fall between periods, which exposes a lost sign or a swapped subtraction in the difference term.

Totals that land exactly on the limit and totals that exceed it show whether saturation and the mode switch both occur. Direct periods with busy strobes confirm that the pulses are ignored. Readings exactly at the return threshold and one below it locate the strict comparison.

// File: rtl/dri_pkg.sv
package dri_pkg;
  typedef enum logic {
    RANGE_COUNT  = 1'b0,
    RANGE_DIRECT = 1'b1
  } range_e;
endpackage

// File: rtl/dri_period_timer.sv
module dri_period_timer #(
  parameter int PERIOD_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int TW = (PERIOD_CYCLES > 1) ? $clog2(PERIOD_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(PERIOD_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R1
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dri_pulse_counter.sv
module dri_pulse_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] total_o
);
  localparam int SW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [SW-1:0]    sum;
  logic [CNT_W-1:0] capped;

  always_comb begin
    sum    = {1'b0, cnt_q} + SW'(up_i) + SW'(dn_i);
    capped = (sum >= {1'b0, limit_i}) ? limit_i : sum[CNT_W-1:0];
    total_o = en_i ? capped : '0;
  end

  // count restarts at every boundary; held clear while direct mode runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= '0;
    else if (en_i)   cnt_q <= capped;
    else             cnt_q <= '0;
  end
endmodule

// File: rtl/dri_range_ctrl.sv
module dri_range_ctrl #(
  parameter int CNT_W = 8,
  parameter int ADC_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [CNT_W-1:0]    total_i,
  input  logic [CNT_W-1:0]    limit_i,
  input  logic [ADC_W-1:0]    adc_i,
  input  logic [ADC_W-1:0]    low_i,
  output dri_pkg::range_e     mode_o
);
  import dri_pkg::*;

  range_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (tick_i) begin
      unique case (mode_q)
        RANGE_COUNT:  if (total_i >= limit_i) mode_d = RANGE_DIRECT;
        RANGE_DIRECT: if (adc_i < low_i)      mode_d = RANGE_COUNT;
        default:      mode_d = RANGE_COUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= RANGE_COUNT;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  // R12
  mode_at_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> $past(tick_i));
endmodule

// File: rtl/dri_sample_combiner.sv
module dri_sample_combiner #(
  parameter int CNT_W        = 8,
  parameter int ADC_W        = 12,
  parameter int OUT_W        = 24,
  parameter int PULSE_SCALE  = 16,
  parameter int ADC_SCALE    = 1,
  parameter int DIRECT_SCALE = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  dri_pkg::range_e         mode_i,
  input  logic [CNT_W-1:0]        total_i,
  input  logic [ADC_W-1:0]        adc_i,
  output logic signed [OUT_W-1:0] sample_o,
  output logic                    valid_o,
  output logic                    tag_o
);
  import dri_pkg::*;

  localparam logic        [OUT_W-1:0] PULSE_K = OUT_W'(PULSE_SCALE);
  localparam logic signed [OUT_W-1:0] ADC_K   = OUT_W'(ADC_SCALE);
  localparam logic        [OUT_W-1:0] DIR_K   = OUT_W'(DIRECT_SCALE);

  logic [ADC_W-1:0]        prev_q;
  logic                    primed_q;
  logic signed [ADC_W:0]   diff;
  logic signed [OUT_W-1:0] diff_ext, diff_term, cnt_term, dir_term, result;

  always_comb begin
    diff      = $signed({1'b0, adc_i}) - $signed({1'b0, prev_q});
    diff_ext  = OUT_W'(diff);
    diff_term = diff_ext * ADC_K;
    cnt_term  = $signed(OUT_W'(total_i) * PULSE_K);
    dir_term  = $signed(OUT_W'(adc_i) * DIR_K);
    result    = (mode_i == RANGE_DIRECT) ? dir_term : cnt_term + diff_term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      valid_o  <= 1'b0;
      sample_o <= '0;
      tag_o    <= 1'b0;
    end else if (tick_i) begin
      prev_q   <= adc_i;
      primed_q <= 1'b1;
      valid_o  <= primed_q;
      if (primed_q) begin
        sample_o <= result;
        tag_o    <= (mode_i == RANGE_DIRECT);
      end
    end else begin
      valid_o <= 1'b0;
    end
  end

  // R4
  valid_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(tick_i));
  // R11
  tag_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (tag_o == ($past(mode_i) == RANGE_DIRECT)));
endmodule

// File: rtl/dri_combiner.sv
module dri_combiner #(
  parameter int PERIOD_CYCLES = 100,
  parameter int CNT_W         = 8,
  parameter int ADC_W         = 12,
  parameter int OUT_W         = 24,
  parameter int PULSE_SCALE   = 16,
  parameter int ADC_SCALE     = 1,
  parameter int DIRECT_SCALE  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_strobe_i,
  input  logic             dn_strobe_i,
  input  logic [ADC_W-1:0] adc_data_i,
  input  logic [CNT_W-1:0] cnt_limit_i,
  input  logic [ADC_W-1:0] direct_low_i,
  output logic             adc_strobe_o,
  output logic             range_o,
  output logic [OUT_W-1:0] sample_o,
  output logic             sample_valid_o,
  output logic             sample_mode_o
);
  import dri_pkg::*;

  logic                    tick;
  range_e                  mode;
  logic [CNT_W-1:0]        total;
  logic signed [OUT_W-1:0] sample_s;

  dri_period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  dri_pulse_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(mode == RANGE_COUNT), .tick_i(tick),
    .up_i(up_strobe_i), .dn_i(dn_strobe_i), .limit_i(cnt_limit_i), .total_o(total)
  );

  dri_range_ctrl #(.CNT_W(CNT_W), .ADC_W(ADC_W)) i_range (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .total_i(total),
    .limit_i(cnt_limit_i), .adc_i(adc_data_i), .low_i(direct_low_i), .mode_o(mode)
  );

  dri_sample_combiner #(
    .CNT_W(CNT_W), .ADC_W(ADC_W), .OUT_W(OUT_W), .PULSE_SCALE(PULSE_SCALE),
    .ADC_SCALE(ADC_SCALE), .DIRECT_SCALE(DIRECT_SCALE)
  ) i_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .mode_i(mode), .total_i(total),
    .adc_i(adc_data_i), .sample_o(sample_s), .valid_o(sample_valid_o), .tag_o(sample_mode_o)
  );

  assign adc_strobe_o = tick;
  assign range_o      = (mode == RANGE_DIRECT);
  assign sample_o     = sample_s;

  // R8
  enter_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_strobe_o && !range_o && (total >= cnt_limit_i)) |=> range_o);
endmodule

// File: tb/test_dri_combiner.sv
module test_dri_combiner;
  localparam int P     = 16;
  localparam int CW    = 6;
  localparam int AW    = 10;
  localparam int OW    = 20;
  localparam int PS    = 16;
  localparam int AS    = 1;
  localparam int DS    = 4;
  localparam int LIMIT = 20;
  localparam int LOW   = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          up = 1'b0, dn = 1'b0;
  logic [AW-1:0] adc = '0;
  logic [CW-1:0] lim = CW'(LIMIT);
  logic [AW-1:0] low = AW'(LOW);
  logic          strobe, range_q, valid, tag;
  logic [OW-1:0] sample;

  int n_chk = 0, n_bad = 0;
  int m_mode = 0, m_prev = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dri_combiner #(
    .PERIOD_CYCLES(P), .CNT_W(CW), .ADC_W(AW), .OUT_W(OW),
    .PULSE_SCALE(PS), .ADC_SCALE(AS), .DIRECT_SCALE(DS)
  ) i_dri_combiner (
    .clk_i(clk), .rst_ni(rst_n), .up_strobe_i(up), .dn_strobe_i(dn),
    .adc_data_i(adc), .cnt_limit_i(lim), .direct_low_i(low),
    .adc_strobe_o(strobe), .range_o(range_q), .sample_o(sample),
    .sample_valid_o(valid), .sample_mode_o(tag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Runs one period starting at the negedge of its cycle 0 and ends at the next cycle 0.
  task automatic run_period(input int n_up, input int n_dn, input int a);
    int exp_s, exp_tag, tot;
    bit early = 1'b0;
    for (int k = 0; k < P; k++) begin
      up  = (k < n_up);
      dn  = (k < n_dn);
      adc = AW'(a);
      #1;
      if (k < P - 1 && strobe) early = 1'b1;
      if (k == P - 1) check(strobe && !early, "R1 strobe position", int'(strobe), 1);
      @(negedge clk);
    end
    up = 1'b0; dn = 1'b0;
    exp_tag = m_mode;
    if (m_mode == 0) begin
      tot = n_up + n_dn;
      if (tot > LIMIT) tot = LIMIT;
      exp_s = tot * PS + (a - m_prev) * AS;
      if (tot >= LIMIT) m_mode = 1;
    end else begin
      exp_s = a * DS;
      if (a < LOW) m_mode = 0;
    end
    m_prev = a;
    check(valid == 1'b1, "R4 valid after boundary", int'(valid), 1);
    check(int'($signed(sample)) == exp_s, (exp_tag != 0) ? "R9 direct integral" :
          "R5/R6/R7 counting integral", int'($signed(sample)), exp_s);
    check(int'(tag) == exp_tag, "R11 sample mode tag", int'(tag), exp_tag);
    check(int'(range_q) == m_mode, "R8/R10/R12 range after boundary", int'(range_q), m_mode);
    @(posedge clk); #1;
    check(valid == 1'b0, "R4 valid single cycle", int'(valid), 0);
    @(negedge clk);
    // one cycle of this period already spent: compensate by shortening is not allowed,
    // so the caller relies on run_rest for the remaining cycles
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 0 && sample == '0 && tag == 0 && range_q == 0 && strobe == 0,
          "R2 reset state", int'(valid) + int'(range_q), 0);
    rst_n = 1'b1;
    adc = AW'(50);
    for (int k = 0; k < P; k++) begin
      #1;
      check(valid == 1'b0, "R3 no sample before priming", int'(valid), 0);
      if (k == P - 1) check(strobe == 1'b1, "R1 first strobe", int'(strobe), 1);
      else if (strobe) check(1'b0, "R1 early strobe", 1, 0);
      @(negedge clk);
    end
    #1;
    check(valid == 1'b0, "R3 priming boundary gives no sample", int'(valid), 0);
    m_prev = 50;
    done = 1'b0;
    // drive periods back to back; run_period consumed one cycle of the next period
    // at its end, so shift by using P-1 first cycles: handled by a wrapper below
    seq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // Periods are aligned: each run_period begins in cycle 0 of its period. The trailing
  // idle cycle in run_period is cycle 1 of the next, so the next period is realigned here.
  task automatic realign();
    while (!strobe) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
  endtask

  task automatic seq();
    // first counting period: start directly at cycle 0
    run_period(0, 0, 50);
    for (int t = 0; t < LIMIT; t++) begin
      realign_fill(m_prev);
      run_period((t + 1) / 2, t / 2, 60 + ((t * 53) % 300));
    end
    realign_fill(m_prev);
    run_period(P, 0, 40);                 // R6 falling, 16 pulses below limit
    realign_fill(m_prev);
    run_period(16, 4, 300);               // R8 exactly at limit
    realign_fill(m_prev);
    run_period(P, P, 300);                // R9 direct, strobes ignored
    realign_fill(m_prev);
    run_period(P, 3, LOW);                // R10 equal stays direct
    realign_fill(m_prev);
    run_period(0, 0, LOW - 1);            // R10 below returns
    realign_fill(m_prev);
    run_period(3, 0, 60);                 // R6 negative difference
    realign_fill(m_prev);
    run_period(0, 0, 20);
    realign_fill(m_prev);
    run_period(P, P, 500);                // R7 saturation, enters direct
    realign_fill(m_prev);
    run_period(0, 0, 5);                  // back to counting
    realign_fill(m_prev);
    run_period(5, 5, 5);                  // R5 both strobes same cycles
  endtask

  // Period boundary check already consumed; the gap cycles of an unmeasured period
  // would corrupt the model, so a filler period with the previous ADC value and no pulses
  // is run and checked as its own sample.
  task automatic realign_fill(input int a);
    int exp_s, exp_tag;
    adc = AW'(a);
    realign();
    exp_tag = m_mode;
    exp_s = (m_mode == 0) ? 0 : a * DS;
    if (m_mode == 1 && a < LOW) m_mode = 0;
    check(int'($signed(sample)) == exp_s, exp_tag ? "R9 direct filler" : "R5 idle filler",
          int'($signed(sample)), exp_s);
    check(int'(range_q) == m_mode, "R12 range after filler", int'(range_q), m_mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule